// File: doc/BRIEF.md
# Two-Wire Audio Control Register Interface

This block is the write-only control port of an audio matrix. It samples the two-wire bus lines (serial clock and open-drain data) with the system clock, recognises START and STOP, matches its own 8-bit write address, and acknowledges each byte of a transaction addressed to it. The first byte after the address is a register pointer. It picks one of four 8-bit control registers and says whether later bytes advance the pointer. Every data byte after it lands in the register being pointed at.

The register contents are decoded into ready-to-use control fields for the analog path. These are an effect enable and a stereo/mono select, plus a mute flag, a fine step field and a coarse step field for each of the three attenuators: the input attenuator and the space and center effect attenuators. After reset every attenuator is muted and the effect is off, so the analog path is silent until a host writes real settings.

A board strap selects one of two bus addresses, so two of these blocks can share a bus. The block never drives the data line high. Its only output on the bus is a pull-down request that the pad turns into an open-drain low.

Top module: `i2c_audio_ctl`

## Requirements
- R1: The block answers only to write address 0x80 when `addr_sel_i` is 0 and only to 0x82 when it is 1; any other first byte, including a read address, is not acknowledged.
- R2: START (data falling while clock is high) begins the address phase. STOP (data rising while clock is high) ends the transaction. Clock pulses after STOP and before a new START are ignored.
- R3: For a matched transaction, the block pulls data low for the whole ninth clock of the address byte, the pointer byte and every data byte. It releases data at every other time.
- R4: In the pointer byte, bits 1:0 select the register (0 mode, 1 space, 2 center, 3 input), bit 7 is the advance flag, and bits 6:2 have no effect.
- R5: With the advance flag clear, every data byte of the transaction is written to the same selected register.
- R6: With the advance flag set, each data byte goes to the register after the previous one, and the index wraps from 3 to 0.
- R7: Input register decode: bits 2:0 are the fine field (0.5 dB steps), bits 5:3 are the coarse field (4 dB steps), and mute is set when bit 6 or bit 7 is 1.
- R8: Space and center register decode: bits 2:0 are the fine field (1 dB steps), bits 4:3 are the coarse field (8 dB steps), mute is bit 5, and bits 7:6 have no effect.
- R9: Mode register decode: bit 0 is the effect enable (1 on, 0 fixed/off) and bit 1 selects stereo (1) or mono (0).
- R10: After reset, the input, space and center mutes are 1, the effect enable and stereo select are 0, and data is released.
- R11: After an address mismatch the block acknowledges nothing and writes nothing until the next START.
- R12: A START in the middle of a byte or transaction discards the partial byte and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| addr_sel_i | input | 1 | Address strap: 0 selects 0x80, 1 selects 0x82 |
| sda_pull_o | output | 1 | 1 requests the pad to pull data low |
| mode_effect_o | output | 1 | Effect enable |
| mode_stereo_o | output | 1 | 1 stereo, 0 mono |
| in_mute_o | output | 1 | Input attenuator mute |
| in_fine_o | output | 3 | Input attenuation, 0.5 dB steps |
| in_coarse_o | output | 3 | Input attenuation, 4 dB steps |
| spc_mute_o | output | 1 | Space attenuator mute |
| spc_fine_o | output | 3 | Space attenuation, 1 dB steps |
| spc_coarse_o | output | 2 | Space attenuation, 8 dB steps |
| ctr_mute_o | output | 1 | Center attenuator mute |
| ctr_fine_o | output | 3 | Center attenuation, 1 dB steps |
| ctr_coarse_o | output | 2 | Center attenuation, 8 dB steps |

## Verification
Some rules are checked by assertions on every cycle. The pull-down may only appear in an acknowledge slot and never after a mismatch. A START always returns the receiver to an empty address phase. A write strobe always lands its byte in the indexed register. The pointer either holds or wraps from 3 to 0 after each write. Reset always leaves every path muted. Other behaviour only shows in bench scenarios that drive whole bus transactions. These cover the strap choosing between the two addresses and a read address being refused. They also cover pointer bits and high register bits having no visible effect, and a partial byte being thrown away on a repeated START. The bench also checks that clocks after STOP write nothing.

// File: rtl/i2c_audio_pkg.sv
// Package: shared constants, register indices, bus phase type and
// power-up register values for the audio control interface.
package i2c_audio_pkg;
    localparam int REG_COUNT = 4;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int BYTE_W    = 8;
    localparam int IN_FINE_W = 3;
    localparam int IN_CRS_W  = 3;
    localparam int SC_FINE_W = 3;
    localparam int SC_CRS_W  = 2;

    localparam logic [IDX_W-1:0] IDX_MODE   = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_SPACE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_CENTER = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_INPUT  = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(REG_COUNT - 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } bus_phase_e;

    // Power-up value: attenuators muted, effect off.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            1, 2:    return BYTE_W'(1 << (SC_FINE_W + SC_CRS_W));
            3:       return BYTE_W'(1 << (IN_FINE_W + IN_CRS_W));
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings the asynchronous bus clock and data lines into the system clock
// domain and reports clock edges plus START and STOP events.
// Assumes the system clock is several times faster than the bus clock.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
    logic scl_prev_q, sda_prev_q;
    logic scl_s, sda_s;

    assign scl_s = scl_sync_q[SYNC_STAGES-1];
    assign sda_s = sda_sync_q[SYNC_STAGES-1];

    // Purpose: multi-flop synchroniser chains, idle-high at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    // Purpose: edge and bus-condition detection on the synchronised lines.
    always_comb begin
        scl_rise_o = scl_s & ~scl_prev_q;
        scl_fall_o = ~scl_s & scl_prev_q;
        sda_o      = sda_s;
        start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
        stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
    end
endmodule

// File: rtl/i2c_byte_rx.sv
// Module: i2c_byte_rx
// Transaction engine: shifts in bytes MSB first, matches the address,
// latches the register pointer, drives acknowledge and issues one write
// strobe per data byte. Assumes events come from i2c_line_sync.
module i2c_byte_rx
    import i2c_audio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] own_addr_i,
    output logic              ack_pull_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

    bus_phase_e        phase_q;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic              in_ack_q, ack_drv_q, auto_q;
    logic [IDX_W-1:0]  idx_q;
    logic              active;

    assign active = (phase_q == PH_ADDR) || (phase_q == PH_SUB) || (phase_q == PH_DATA);

    // Purpose: bus phase sequencing, bit shifting, acknowledge and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= '0;
            shift_q   <= '0;
            in_ack_q  <= 1'b0;
            ack_drv_q <= 1'b0;
            auto_q    <= 1'b0;
            idx_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_i) begin
                phase_q   <= PH_ADDR;
                bit_cnt_q <= '0;
                in_ack_q  <= 1'b0;
                ack_drv_q <= 1'b0;
            end else if (stop_i) begin
                phase_q   <= PH_IDLE;
                bit_cnt_q <= '0;
                in_ack_q  <= 1'b0;
                ack_drv_q <= 1'b0;
            end else if (active) begin
                if (scl_fall_i && in_ack_q) begin
                    in_ack_q  <= 1'b0;
                    ack_drv_q <= 1'b0;
                    bit_cnt_q <= '0;
                end else if (scl_rise_i && !in_ack_q && bit_cnt_q != BITS_FULL) begin
                    shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (scl_fall_i && bit_cnt_q == BITS_FULL) begin
                    in_ack_q  <= 1'b1;
                    ack_drv_q <= 1'b1;
                    case (phase_q)
                        PH_ADDR: begin
                            if (shift_q == own_addr_i) begin
                                phase_q <= PH_SUB;
                            end else begin
                                phase_q   <= PH_SKIP;
                                in_ack_q  <= 1'b0;
                                ack_drv_q <= 1'b0;
                            end
                        end
                        PH_SUB: begin
                            auto_q  <= shift_q[BYTE_W-1];
                            idx_q   <= shift_q[IDX_W-1:0];
                            phase_q <= PH_DATA;
                        end
                        default: begin
                            wr_en_o   <= 1'b1;
                            wr_idx_o  <= idx_q;
                            wr_data_o <= shift_q;
                            if (auto_q) begin
                                idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign ack_pull_o = ack_drv_q;

    // R3: the pull-down only ever appears inside an acknowledge slot.
    p_ack_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drv_q |-> in_ack_q);
    // R11: a mismatched transaction never acknowledges.
    p_skip_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP) |-> !ack_drv_q && !wr_en_o);
    // R12: a START always leaves an empty address phase.
    p_start_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (phase_q == PH_ADDR) && (bit_cnt_q == 4'd0) && !ack_drv_q);
    // R6: advancing pointer wraps from the last register to the first.
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && auto_q && wr_idx_o == IDX_LAST) |-> (idx_q == '0));
    // R5: without the advance flag the pointer holds after a write.
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !auto_q) |-> (idx_q == wr_idx_o));
    // R4: write strobes come only from the data phase.
    p_wr_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (phase_q == PH_DATA));
endmodule

// File: rtl/i2c_audio_regs.sv
// Module: i2c_audio_regs
// Bank of control registers loaded by the write strobe, reset to the
// muted power-up values. Assumes at most one write per cycle.
module i2c_audio_regs
    import i2c_audio_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [IDX_W-1:0]                  wr_idx_i,
    input  logic [BYTE_W-1:0]                 wr_data_i,
    output logic [REG_COUNT-1:0][BYTE_W-1:0]  bank_o
);
    logic [REG_COUNT-1:0][BYTE_W-1:0] bank_q;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // Purpose: one control register with its own power-up value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= reg_default(g);
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                bank_q[g] <= wr_data_i;
            end
        end
    end

    assign bank_o = bank_q;

    // R4: a write strobe lands its byte in the indexed register.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (bank_q[$past(wr_idx_i)] == $past(wr_data_i)));
    // R10: reset leaves every attenuator muted and the effect off.
    p_reset_muted_r10: assert property (@(posedge clk)
        !rst_n |=> bank_q[IDX_INPUT][IN_FINE_W+IN_CRS_W]
                   && bank_q[IDX_SPACE][SC_FINE_W+SC_CRS_W]
                   && bank_q[IDX_CENTER][SC_FINE_W+SC_CRS_W]
                   && (bank_q[IDX_MODE][1:0] == 2'b00));
endmodule

// File: rtl/i2c_audio_decode.sv
// Module: i2c_audio_decode
// Splits the register bank into control fields for the analog path.
// Purely combinational; the two effect attenuators share one layout.
module i2c_audio_decode
    import i2c_audio_pkg::*;
(
    input  logic [REG_COUNT-1:0][BYTE_W-1:0] bank_i,
    output logic                 mode_effect_o,
    output logic                 mode_stereo_o,
    output logic                 in_mute_o,
    output logic [IN_FINE_W-1:0] in_fine_o,
    output logic [IN_CRS_W-1:0]  in_coarse_o,
    output logic [1:0]           sc_mute_o,
    output logic [1:0][SC_FINE_W-1:0] sc_fine_o,
    output logic [1:0][SC_CRS_W-1:0]  sc_coarse_o
);
    localparam int IN_MUTE_LSB = IN_FINE_W + IN_CRS_W;
    localparam int SC_MUTE_BIT = SC_FINE_W + SC_CRS_W;

    logic unused_bits;

    // Purpose: mode and input attenuator field extraction.
    always_comb begin
        mode_effect_o = bank_i[IDX_MODE][0];
        mode_stereo_o = bank_i[IDX_MODE][1];
        in_fine_o     = bank_i[IDX_INPUT][IN_FINE_W-1:0];
        in_coarse_o   = bank_i[IDX_INPUT][IN_FINE_W +: IN_CRS_W];
        in_mute_o     = |bank_i[IDX_INPUT][BYTE_W-1:IN_MUTE_LSB];
    end

    for (genvar k = 0; k < 2; k++) begin : g_sc
        localparam logic [IDX_W-1:0] SRC = (k == 0) ? IDX_SPACE : IDX_CENTER;
        // Purpose: stepped attenuator fields for space (k=0) and center (k=1).
        always_comb begin
            sc_fine_o[k]   = bank_i[SRC][SC_FINE_W-1:0];
            sc_coarse_o[k] = bank_i[SRC][SC_FINE_W +: SC_CRS_W];
            sc_mute_o[k]   = bank_i[SRC][SC_MUTE_BIT];
        end
    end

    assign unused_bits = ^{bank_i[IDX_MODE][BYTE_W-1:2],
                           bank_i[IDX_SPACE][BYTE_W-1:SC_MUTE_BIT+1],
                           bank_i[IDX_CENTER][BYTE_W-1:SC_MUTE_BIT+1]};
endmodule

// File: rtl/i2c_audio_ctl.sv
// Module: i2c_audio_ctl (top)
// Write-only two-wire control port for an audio matrix: line sync,
// transaction engine, register bank and field decode.
// Assumes the pad turns sda_pull_o into an open-drain low.
module i2c_audio_ctl
    import i2c_audio_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ADDR_LO     = 8'h80,
    parameter logic [7:0]  ADDR_HI     = 8'h82
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 addr_sel_i,
    output logic                 sda_pull_o,
    output logic                 mode_effect_o,
    output logic                 mode_stereo_o,
    output logic                 in_mute_o,
    output logic [IN_FINE_W-1:0] in_fine_o,
    output logic [IN_CRS_W-1:0]  in_coarse_o,
    output logic                 spc_mute_o,
    output logic [SC_FINE_W-1:0] spc_fine_o,
    output logic [SC_CRS_W-1:0]  spc_coarse_o,
    output logic                 ctr_mute_o,
    output logic [SC_FINE_W-1:0] ctr_fine_o,
    output logic [SC_CRS_W-1:0]  ctr_coarse_o
);
    logic scl_rise, scl_fall, sda_s, start_evt, stop_evt;
    logic wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data, own_addr;
    logic [REG_COUNT-1:0][BYTE_W-1:0] bank;
    logic [1:0] sc_mute;
    logic [1:0][SC_FINE_W-1:0] sc_fine;
    logic [1:0][SC_CRS_W-1:0]  sc_coarse;

    assign own_addr = addr_sel_i ? ADDR_HI : ADDR_LO;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .sda_o(sda_s),
        .start_o(start_evt), .stop_o(stop_evt));

    i2c_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .sda_i(sda_s), .start_i(start_evt), .stop_i(stop_evt),
        .own_addr_i(own_addr), .ack_pull_o(sda_pull_o), .wr_en_o(wr_en),
        .wr_idx_o(wr_idx), .wr_data_o(wr_data));

    i2c_audio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .bank_o(bank));

    i2c_audio_decode u_dec (
        .bank_i(bank), .mode_effect_o(mode_effect_o), .mode_stereo_o(mode_stereo_o),
        .in_mute_o(in_mute_o), .in_fine_o(in_fine_o), .in_coarse_o(in_coarse_o),
        .sc_mute_o(sc_mute), .sc_fine_o(sc_fine), .sc_coarse_o(sc_coarse));

    assign spc_mute_o   = sc_mute[0];
    assign spc_fine_o   = sc_fine[0];
    assign spc_coarse_o = sc_coarse[0];
    assign ctr_mute_o   = sc_mute[1];
    assign ctr_fine_o   = sc_fine[1];
    assign ctr_coarse_o = sc_coarse[1];
endmodule

// File: tb/i2c_audio_ctl_tb_top.sv
// Bench: drives whole bus transactions and keeps a behavioural model
// (register array, phase integer) compared against the outputs on every
// settled clock, plus named scenario checks.
module i2c_audio_ctl_tb_top;
    localparam int HALF = 20;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, scl_m, sda_m, addr_sel, sda_line;
    logic sda_pull, m_eff, m_st, in_mute, spc_mute, ctr_mute;
    logic [2:0] in_fine, in_crs, spc_fine, ctr_fine;
    logic [1:0] spc_crs, ctr_crs;

    assign sda_line = sda_m & ~sda_pull;

    i2c_audio_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull),
        .mode_effect_o(m_eff), .mode_stereo_o(m_st),
        .in_mute_o(in_mute), .in_fine_o(in_fine), .in_coarse_o(in_crs),
        .spc_mute_o(spc_mute), .spc_fine_o(spc_fine), .spc_coarse_o(spc_crs),
        .ctr_mute_o(ctr_mute), .ctr_fine_o(ctr_fine), .ctr_coarse_o(ctr_crs));

    int checks = 0, errors = 0, quiet = 0;
    logic [7:0] m_reg [4];
    int m_phase;   // 0 idle, 1 address, 2 pointer, 3 data, 4 skip
    int m_idx;
    logic m_auto, m_ack;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_reg[0] = 8'h00; m_reg[1] = 8'h20; m_reg[2] = 8'h20; m_reg[3] = 8'h40;
        m_phase = 0; m_idx = 0; m_auto = 0; m_ack = 0;
    endtask

    // Model reaction to a completed byte; returns the expected acknowledge.
    function automatic logic model_byte(logic [7:0] b);
        logic [7:0] own;
        own = addr_sel ? 8'h82 : 8'h80;
        case (m_phase)
            1: begin
                if (b == own) begin m_phase = 2; return 1'b1; end
                m_phase = 4; return 1'b0;
            end
            2: begin m_auto = b[7]; m_idx = int'(b[1:0]); m_phase = 3; return 1'b1; end
            3: begin
                m_reg[m_idx] = b;
                if (m_auto) m_idx = (m_idx + 1) % 4;
                return 1'b1;
            end
            default: return 1'b0;
        endcase
    endfunction

    // Per-clock comparison against the model once the lines have settled.
    always @(negedge clk) begin
        if (quiet > 0) quiet--;
        else if (rst_n) begin
            chk("R3 sda_pull", int'(sda_pull), int'(m_ack));
            chk("R9 effect", int'(m_eff), int'(m_reg[0][0]));
            chk("R9 stereo", int'(m_st), int'(m_reg[0][1]));
            chk("R7 in_mute", int'(in_mute), int'(m_reg[3][7] | m_reg[3][6]));
            chk("R7 in_fine", int'(in_fine), int'(m_reg[3][2:0]));
            chk("R7 in_coarse", int'(in_crs), int'(m_reg[3][5:3]));
            chk("R8 spc_mute", int'(spc_mute), int'(m_reg[1][5]));
            chk("R8 spc_fine", int'(spc_fine), int'(m_reg[1][2:0]));
            chk("R8 spc_coarse", int'(spc_crs), int'(m_reg[1][4:3]));
            chk("R8 ctr_mute", int'(ctr_mute), int'(m_reg[2][5]));
            chk("R8 ctr_fine", int'(ctr_fine), int'(m_reg[2][2:0]));
            chk("R8 ctr_coarse", int'(ctr_crs), int'(m_reg[2][4:3]));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_scl(logic v);
        scl_m = v; quiet = SETTLE; tick(HALF);
    endtask

    task automatic set_sda(logic v);
        sda_m = v; quiet = SETTLE; tick(HALF / 2);
    endtask

    task automatic bus_start();
        set_sda(1'b1);
        set_scl(1'b1);
        sda_m = 1'b0; quiet = SETTLE; m_phase = 1; m_ack = 0;
        tick(HALF);
        set_scl(1'b0);
    endtask

    task automatic bus_stop();
        set_sda(1'b0);
        set_scl(1'b1);
        sda_m = 1'b1; quiet = SETTLE; m_phase = 0; m_ack = 0;
        tick(HALF);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            set_sda(b[i]);
            set_scl(1'b1);
            set_scl(1'b0);
        end
    endtask

    // Full byte with acknowledge slot; checks the pull in the ninth clock.
    task automatic send_byte(logic [7:0] b, logic exp_ack, string tag);
        logic a;
        send_bits(b, 7);
        set_sda(b[0]);
        set_scl(1'b1);
        scl_m = 1'b0; quiet = SETTLE;
        a = model_byte(b);
        m_ack = a;
        tick(HALF / 2);
        sda_m = 1'b1; quiet = SETTLE;
        tick(HALF / 2);
        scl_m = 1'b1; quiet = SETTLE;
        tick(HALF / 2);
        @(negedge clk);
        chk({tag, " ack slot"}, int'(!sda_line), int'(exp_ack));
        tick(HALF / 2);
        scl_m = 1'b0; m_ack = 0; quiet = SETTLE;
        tick(HALF);
    endtask

    task automatic settle();
        tick(SETTLE + 2);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
        model_reset();
        tick(5);
        @(negedge clk);
        // R10: reset state
        chk("R10 in_mute", int'(in_mute), 1);
        chk("R10 spc_mute", int'(spc_mute), 1);
        chk("R10 ctr_mute", int'(ctr_mute), 1);
        chk("R10 effect", int'(m_eff), 0);
        chk("R10 stereo", int'(m_st), 0);
        chk("R10 sda_pull", int'(sda_pull), 0);
        rst_n = 1'b1; quiet = SETTLE;
        tick(20);

        // R1/R4/R7: single input write at the low address
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr 0x80");
        send_byte(8'h03, 1'b1, "R3 pointer");
        send_byte(8'h2D, 1'b1, "R3 data");
        bus_stop();
        settle();
        chk("R7 in_fine 0x2D", int'(in_fine), 5);
        chk("R7 in_coarse 0x2D", int'(in_crs), 5);
        chk("R7 in_mute 0x2D", int'(in_mute), 0);

        // R6/R4: advancing writes from space, pointer bits 6:2 set, wrap to mode
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr");
        send_byte(8'hFD, 1'b1, "R4 pointer 0xFD");
        send_byte(8'h13, 1'b1, "R6 data space");
        send_byte(8'h25, 1'b1, "R6 data center");
        send_byte(8'h78, 1'b1, "R6 data input");
        send_byte(8'h03, 1'b1, "R6 data mode wrap");
        bus_stop();
        settle();
        chk("R8 spc_fine", int'(spc_fine), 3);
        chk("R8 spc_coarse", int'(spc_crs), 2);
        chk("R8 spc_mute", int'(spc_mute), 0);
        chk("R8 ctr_mute 0x25", int'(ctr_mute), 1);
        chk("R6 in_coarse", int'(in_crs), 7);
        chk("R6 wrap effect", int'(m_eff), 1);
        chk("R9 stereo", int'(m_st), 1);

        // R5/R8: repeated writes to center, bits 7:6 ignored
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr");
        send_byte(8'h7E, 1'b1, "R4 pointer 0x7E");
        send_byte(8'h01, 1'b1, "R5 data1");
        send_byte(8'h04, 1'b1, "R5 data2");
        send_byte(8'hC7, 1'b1, "R5 data3");
        bus_stop();
        settle();
        chk("R5 ctr_fine", int'(ctr_fine), 7);
        chk("R8 ctr_coarse", int'(ctr_crs), 0);
        chk("R8 ctr_mute high bits", int'(ctr_mute), 0);
        chk("R5 spc untouched", int'(spc_fine), 3);

        // R7: mute code then top non-mute code
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr");
        send_byte(8'h03, 1'b1, "R4 pointer");
        send_byte(8'h40, 1'b1, "R7 data 0x40");
        settle();
        chk("R7 in_mute 0x40", int'(in_mute), 1);
        send_byte(8'h3F, 1'b1, "R7 data 0x3F");
        settle();
        chk("R7 in_mute 0x3F", int'(in_mute), 0);
        chk("R7 in_fine 0x3F", int'(in_fine), 7);
        bus_stop();

        // R9: mono effect
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr");
        send_byte(8'h00, 1'b1, "R4 pointer mode");
        send_byte(8'h01, 1'b1, "R9 data");
        bus_stop();
        settle();
        chk("R9 effect mono", int'(m_eff), 1);
        chk("R9 stereo mono", int'(m_st), 0);

        // R11: wrong address and read address are refused, nothing written
        bus_start();
        send_byte(8'h84, 1'b0, "R11 addr 0x84");
        send_byte(8'h00, 1'b0, "R11 byte");
        send_byte(8'hFF, 1'b0, "R11 byte");
        bus_stop();
        bus_start();
        send_byte(8'h81, 1'b0, "R1 read addr");
        send_byte(8'h02, 1'b0, "R11 byte");
        bus_stop();
        settle();
        chk("R11 effect kept", int'(m_eff), 1);
        chk("R11 stereo kept", int'(m_st), 0);

        // R1: strap high moves the address to 0x82
        addr_sel = 1'b1; quiet = SETTLE; tick(10);
        bus_start();
        send_byte(8'h80, 1'b0, "R1 strap 0x80 refused");
        send_byte(8'h03, 1'b0, "R11 byte");
        send_byte(8'h00, 1'b0, "R11 byte");
        bus_stop();
        bus_start();
        send_byte(8'h82, 1'b1, "R1 strap 0x82");
        send_byte(8'h03, 1'b1, "R4 pointer");
        send_byte(8'h11, 1'b1, "R1 data");
        bus_stop();
        settle();
        chk("R1 in_fine", int'(in_fine), 1);
        chk("R1 in_coarse", int'(in_crs), 2);
        addr_sel = 1'b0; quiet = SETTLE; tick(10);

        // R12: repeated START inside a data byte
        bus_start();
        send_byte(8'h80, 1'b1, "R1 addr");
        send_byte(8'h03, 1'b1, "R4 pointer");
        send_bits(8'h00, 4);
        bus_start();
        send_byte(8'h80, 1'b1, "R12 addr again");
        send_byte(8'h01, 1'b1, "R12 pointer");
        send_byte(8'h2A, 1'b1, "R12 data");
        bus_stop();
        settle();
        chk("R12 input kept fine", int'(in_fine), 1);
        chk("R12 input kept coarse", int'(in_crs), 2);
        chk("R12 spc_mute", int'(spc_mute), 1);

        // R2: clocks after STOP without START are ignored
        send_byte(8'h80, 1'b0, "R2 after stop");
        send_byte(8'h00, 1'b0, "R2 after stop");
        set_sda(1'b1);
        settle();
        chk("R2 effect kept", int'(m_eff), 1);

        // R10: reset in mid-run restores muted defaults
        rst_n = 1'b0; model_reset(); quiet = SETTLE;
        tick(3);
        @(negedge clk);
        chk("R10 in_mute again", int'(in_mute), 1);
        chk("R10 spc_mute again", int'(spc_mute), 1);
        chk("R10 effect again", int'(m_eff), 0);
        rst_n = 1'b1;
        tick(20);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule